// File: doc/BRIEF.md
# Flash Protected Range Guard

This block sits between a flash cycle sequencer and the serial flash engine. It decides, in the cycle in which a flash cycle is started, whether that cycle may go out to the flash device. It holds a small set of protected-range registers. Each register names a window of flash space at 4 KiB granularity and carries its own read-protect and write-protect enables. Write-protect covers both program and erase cycles.

Software loads the range registers freely while the block is unlocked. While unlocked, no protection is applied. Once the lock input is pulsed, the block enters lockdown. From then on every register is frozen, further writes are dropped without notice, and every cycle is checked against all enabled ranges. A blocked cycle raises a one-cycle error instead of the allow strobe. Only reset leaves lockdown.

Top module: `flash_range_guard`

## Requirements
- R1: After reset the block is unlocked, and every range register reads back as 0x00000000.
- R2: While unlocked, a register write stores the word. Read-back places the write-protect enable at bit 31, the upper page limit at bits 28:16, the read-protect enable at bit 15 and the lower page limit at bits 12:0. Bits 30:29 and 14:13 always read as zero.
- R3: A pulse on `lock_set_i` sets `locked_o` from the next clock edge on. It stays set until reset.
- R4: Register writes made while `locked_o` is 1 are dropped, and the read-back value and the protection do not change.
- R5: While unlocked, every started cycle is allowed and no error is raised, whatever the range contents.
- R6: While locked, a cycle of kind write (1), erase (2) or reserved kind (3) is blocked if its address lies in any range whose write-protect enable is set. A blocked cycle gives `cyc_err_o`=1 and `cyc_allow_o`=0 in the same cycle as `cyc_start_i`.
- R7: While locked, a read (kind 0) is blocked only by ranges with read-protect set. A read-protect-only range does not block writes, and a write-protect-only range does not block reads.
- R8: A range covers addresses from lower*4096 up to upper*4096+4095, both ends inclusive. The addresses one below and one above that span are not covered.
- R9: A range with both enables clear blocks nothing. A range whose lower limit exceeds its upper limit covers no address.
- R10: When `cyc_start_i` is low, both `cyc_allow_o` and `cyc_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Range register write strobe |
| cfg_idx_i | input | 3 | Range register index for both write and read-back |
| cfg_wdata_i | input | 32 | Range register write data |
| cfg_rdata_o | output | 32 | Read-back of the indexed range register |
| lock_set_i | input | 1 | Enter lockdown |
| locked_o | output | 1 | Lockdown state |
| cyc_start_i | input | 1 | Flash cycle start strobe |
| cyc_kind_i | input | 2 | 0 read, 1 write, 2 erase, 3 reserved (checked as write) |
| cyc_addr_i | input | 25 | Flash byte address of the cycle |
| cyc_allow_o | output | 1 | Cycle may proceed |
| cyc_err_o | output | 1 | Cycle blocked, cycle error |

## Verification
The hardest situation to reach is a protected range taking effect, because protection only applies after lockdown, and lockdown then stops any further reprogramming. The stimulus first writes an all-ones word to check the reserved bits. It then loads every range with a pattern that mixes read-only, write-only and both-enabled windows, a disabled full-space window and an inverted window. It confirms that nothing is blocked, and then locks. The exact page edges are then probed one address inside and one outside each window. A write attempted after lockdown is followed by a read-back and a repeated probe. A final reset shows that lockdown and the contents are gone.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int ADDR_W     = 25;
  localparam int PAGE_SHIFT = 12;
  localparam int LIM_W      = ADDR_W - PAGE_SHIFT;
  localparam int WORD_W     = 32;
  // word layout is the software view
  localparam int WP_BIT = 31;
  localparam int HI_LSB = 16;
  localparam int RP_BIT = 15;
  localparam int LO_LSB = 0;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_ERASE = 2'd2,
    KIND_RSVD  = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    logic             wp;
    logic [LIM_W-1:0] hi;
    logic             rp;
    logic [LIM_W-1:0] lo;
  } range_t;

  function automatic logic [WORD_W-1:0] pack_word(range_t r);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WP_BIT] = r.wp;
    w[HI_LSB +: LIM_W] = r.hi;
    w[RP_BIT] = r.rp;
    w[LO_LSB +: LIM_W] = r.lo;
    return w;
  endfunction

  function automatic range_t unpack_word(logic [WORD_W-1:0] w);
    range_t r;
    r.wp = w[WP_BIT];
    r.hi = w[HI_LSB +: LIM_W];
    r.rp = w[RP_BIT];
    r.lo = w[LO_LSB +: LIM_W];
    return r;
  endfunction
endpackage

// File: rtl/fpr_range_reg.sv
module fpr_range_reg
  import fpr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              locked_i,
  output range_t            cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_o <= '0;
    else if (we_i && !locked_i) cfg_o <= unpack_word(wdata_i);
  end

  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(cfg_o));
endmodule

// File: rtl/fpr_range_hit.sv
module fpr_range_hit
  import fpr_pkg::*;
(
  input  range_t           cfg_i,
  input  logic [LIM_W-1:0] page_i,
  input  logic             is_read_i,
  output logic             hit_o
);
  logic in_span, armed;
  assign in_span = (page_i >= cfg_i.lo) && (page_i <= cfg_i.hi);
  assign armed   = is_read_i ? cfg_i.rp : cfg_i.wp;
  assign hit_o   = armed && in_span;
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import fpr_pkg::*;
#(
  parameter  int NUM_RANGES = 5,
  localparam int IDX_W = (NUM_RANGES > 4) ? $clog2(NUM_RANGES) : 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  input  logic              lock_set_i,
  output logic              locked_o,
  input  logic              cyc_start_i,
  input  logic [1:0]        cyc_kind_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  output logic              cyc_allow_o,
  output logic              cyc_err_o
);
  range_t                 cfg   [NUM_RANGES];
  logic [NUM_RANGES-1:0]  hit;
  logic [LIM_W-1:0]       page;
  logic                   is_read, blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         locked_o <= 1'b0;
    else if (lock_set_i) locked_o <= 1'b1;
  end

  assign page    = cyc_addr_i[ADDR_W-1:PAGE_SHIFT];
  assign is_read = (cyc_kind_e'(cyc_kind_i) == KIND_READ);

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    fpr_range_reg u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
      .wdata_i  (cfg_wdata_i),
      .locked_i (locked_o),
      .cfg_o    (cfg[g])
    );
    fpr_range_hit u_hit (
      .cfg_i     (cfg[g]),
      .page_i    (page),
      .is_read_i (is_read),
      .hit_o     (hit[g])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (cfg_idx_i == IDX_W'(i)) cfg_rdata_o = pack_word(cfg[i]);
  end

  assign blocked     = locked_o && (|hit);
  assign cyc_allow_o = cyc_start_i && !blocked;
  assign cyc_err_o   = cyc_start_i && blocked;

  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  a_r3_lock_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_set_i |=> locked_o);
  a_r5_open_before_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> !cyc_err_o);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cyc_allow_o, cyc_err_o}));
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_start_i |-> !(cyc_allow_o || cyc_err_o));
endmodule

// File: tb/sim_flash_range_guard.sv
module sim_flash_range_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        lock_set_i = 1'b0, locked_o;
  logic        cyc_start_i = 1'b0;
  logic [1:0]  cyc_kind_i = '0;
  logic [24:0] cyc_addr_i = '0;
  logic        cyc_allow_o, cyc_err_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_range_guard u0 (.*);

  // {kind, addr, exp_block}
  typedef struct packed { logic [1:0] kind; logic [24:0] addr; logic blk; } vec_t;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 25'h0010000, 1'b1},  // R8 lower edge
    '{2'd2, 25'h001FFFF, 1'b1},  // R8 upper edge, erase R6
    '{2'd1, 25'h000FFFF, 1'b0},  // R8 below
    '{2'd1, 25'h0020000, 1'b0},  // R8 above
    '{2'd0, 25'h0015000, 1'b0},  // R7 read in wp-only
    '{2'd0, 25'h0100000, 1'b1},  // R7 read in rp-only
    '{2'd0, 25'h0100FFF, 1'b1},  // R7/R8
    '{2'd1, 25'h0100800, 1'b0},  // R7 write in rp-only
    '{2'd0, 25'h0101000, 1'b0},  // R8 above rp range
    '{2'd0, 25'h1FFFFFF, 1'b1},  // R6/R7 both-enabled top
    '{2'd2, 25'h1FFF000, 1'b1},  // R6 erase top
    '{2'd1, 25'h0045000, 1'b0},  // R9 disabled + inverted
    '{2'd3, 25'h0018000, 1'b1}   // R6 reserved kind as write
  };

  function automatic logic [31:0] mk(logic wp, logic rp, logic [12:0] hi, logic [12:0] lo);
    return {wp, 2'b00, hi, rp, 2'b00, lo};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk_i);
    cfg_idx_i = 3'(idx); cfg_wdata_i = d; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_chk(string req, int idx, logic [31:0] exp);
    @(negedge clk_i);
    cfg_idx_i = 3'(idx);
    #1 chk(req, cfg_rdata_o, exp);
  endtask

  // returns {allow, err}
  task automatic probe(string req, logic [1:0] k, logic [24:0] a, logic blk);
    @(negedge clk_i);
    cyc_kind_i = k; cyc_addr_i = a; cyc_start_i = 1'b1;
    #1 chk(req, {30'd0, cyc_allow_o, cyc_err_o}, {30'd0, !blk, blk});
    @(negedge clk_i);
    cyc_start_i = 1'b0;
  endtask

  task automatic load_cfg();
    wr(0, mk(1, 0, 13'h001F, 13'h0010));
    wr(1, mk(0, 1, 13'h0100, 13'h0100));
    wr(2, mk(1, 1, 13'h1FFF, 13'h1FFF));
    wr(3, mk(0, 0, 13'h1FFF, 13'h0000));
    wr(4, mk(1, 0, 13'h0040, 13'h0050));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 locked", {31'd0, locked_o}, 32'd0);
    for (int i = 0; i < 5; i++) rd_chk("R1 rdata", i, 32'h0);
    // R10 idle
    #1 chk("R10 idle", {30'd0, cyc_allow_o, cyc_err_o}, 32'd0);
    // R2 reserved bits
    wr(4, 32'hFFFF_FFFF);
    rd_chk("R2 reserved", 4, 32'h9FFF_9FFF);
    load_cfg();
    rd_chk("R2 layout", 0, 32'h801F_0010);
    rd_chk("R2 layout", 1, 32'h0100_8100);
    // R5 open before lock
    probe("R5 unlocked write", 2'd1, 25'h0010000, 1'b0);
    probe("R5 unlocked read", 2'd0, 25'h0100000, 1'b0);
    // R3 lock
    @(negedge clk_i); lock_set_i = 1'b1;
    @(negedge clk_i); lock_set_i = 1'b0;
    chk("R3 locked", {31'd0, locked_o}, 32'd1);
    repeat (3) @(negedge clk_i);
    chk("R3 sticky", {31'd0, locked_o}, 32'd1);
    // table walk
    for (int v = 0; v < NV; v++)
      probe($sformatf("R6-table v%0d", v), VECS[v].kind, VECS[v].addr, VECS[v].blk);
    // R10 idle while locked over protected address
    @(negedge clk_i); cyc_kind_i = 2'd1; cyc_addr_i = 25'h0010000;
    #1 chk("R10 idle locked", {30'd0, cyc_allow_o, cyc_err_o}, 32'd0);
    // R4 writes dropped after lock
    wr(0, 32'h0);
    rd_chk("R4 rdata kept", 0, 32'h801F_0010);
    probe("R4 still blocks", 2'd1, 25'h0010000, 1'b1);
    wr(3, mk(1, 1, 13'h1FFF, 13'h0000));
    probe("R4 no new range", 2'd1, 25'h0030000, 1'b0);
    // R1 reset clears lockdown
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1 unlock on reset", {31'd0, locked_o}, 32'd0);
    rd_chk("R1 cleared", 2, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule